// File: doc/BRIEF.md
# Prefix Field Override Between Fetch and Decode

This block sits on the path from instruction fetch to decode in a small pipelined core. A prefix instruction can use it to change fields of the next instruction that reaches decode. Nothing is written back to instruction memory, so the stored copy of the modified instruction stays unchanged. The block splits each fetched word into an instruction code, a destination pointer and a source pointer. It also carries a result-register pointer of its own. That pointer normally copies the destination field, and a prefix can replace it.

There are two prefix kinds. A redirect prefix changes only the write-back target of the following instruction. An alter-all prefix replaces the result, destination and source pointers together, taking them from a packed operand value. A prefix whose condition fails arms nothing. A taken branch clears any override that is waiting.

Top module: `fld_override`

## Requirements
- R1: During reset and in the first cycle after it, with no input activity, `dec_valid` is 0 and every field output is 0.
- R2: With no override pending, a word accepted with `in_valid` (and no `flush`) appears one cycle later with `dec_valid`=1. The fields are `dec_code`=word[31:18], `dec_dst`=word[17:9] and `dec_src`=word[8:0]. `dec_res` equals `dec_dst`.
- R3: After an armed redirect prefix (`pfx_kind`=0), the next decoded word has `dec_res`=operand[8:0]. Its code, destination and source stay as encoded in the word.
- R4: After an armed alter-all prefix (`pfx_kind`=1), the next decoded word has `dec_res`=operand[27:19], `dec_dst`=operand[17:9] and `dec_src`=operand[8:0]. Its code stays as encoded.
- R5: An override applies to one decode only. The next decode of the same word uses its encoded fields.
- R6: A prefix presented with `pfx_cond_ok`=0 arms nothing. The next decoded word is unmodified.
- R7: An override waits through cycles without `in_valid`. If a word is decoded in the same cycle that a new prefix arms, that word consumes the earlier override and the new one applies to the word after it.
- R8: `flush` clears any pending override and ignores a prefix or word presented in the same cycle. `dec_valid` is 0 one cycle later.
- R9: In a cycle without `in_valid`, `dec_valid` is 0 one cycle later and the field outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Taken-branch flush; clears the pending override |
| in_valid | input | 1 | A fetched word enters decode this cycle |
| in_word | input | 32 | Fetched instruction word |
| pfx_valid | input | 1 | A prefix is executing this cycle |
| pfx_kind | input | 1 | 0 = redirect result, 1 = alter all fields |
| pfx_cond_ok | input | 1 | The prefix's condition passed |
| pfx_operand | input | 32 | Operand value of the executing prefix |
| dec_valid | output | 1 | Decoded field set is valid |
| dec_code | output | 14 | Instruction code field |
| dec_dst | output | 9 | Destination operand pointer |
| dec_src | output | 9 | Source operand pointer |
| dec_res | output | 9 | Write-back register pointer |

## Verification
The hardest case to reach from the ports is a decode and a prefix arm landing in the same cycle while an older override is still pending, because it needs three events lined up (R7). The directed sequence builds it on purpose: a redirect is armed, then a word is decoded in the same cycle as an alter-all prefix, then a plain word follows. Long random runs also raise `in_valid`, `pfx_valid` and `flush` on their own, which produces many further overlaps, including flushes that hit a pending override.

// File: rtl/fld_ovr_pkg.sv
package fld_ovr_pkg;
    parameter int WORD_W  = 32;
    parameter int PTR_W   = 9;
    parameter int CODE_W  = WORD_W - 2 * PTR_W;
    parameter int SRC_LSB = 0;
    parameter int DST_LSB = PTR_W;
    parameter int CODE_LSB = 2 * PTR_W;
    parameter int RES_LSB = 2 * PTR_W + 1;

    typedef enum logic [1:0] {
        OVR_NONE = 2'd0,
        OVR_RES  = 2'd1,
        OVR_ALL  = 2'd2
    } ovr_mode_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [PTR_W-1:0]  dst;
        logic [PTR_W-1:0]  src;
        logic [PTR_W-1:0]  res;
    } fields_t;

    typedef struct packed {
        ovr_mode_e        mode;
        logic [PTR_W-1:0] res;
        logic [PTR_W-1:0] dst;
        logic [PTR_W-1:0] src;
    } pend_t;
endpackage

// File: rtl/fld_split.sv
module fld_split
    import fld_ovr_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fields_t           f
);
    always_comb begin
        f.code = word[CODE_LSB +: CODE_W];
        f.dst  = word[DST_LSB +: PTR_W];
        f.src  = word[SRC_LSB +: PTR_W];
        f.res  = word[DST_LSB +: PTR_W];
    end
endmodule

// File: rtl/fld_pend_build.sv
module fld_pend_build
    import fld_ovr_pkg::*;
(
    input  logic              kind,
    input  logic [WORD_W-1:0] operand,
    output pend_t             pend
);
    always_comb begin
        pend = '0;
        if (kind) begin
            pend.mode = OVR_ALL;
            pend.res  = operand[RES_LSB +: PTR_W];
            pend.dst  = operand[DST_LSB +: PTR_W];
            pend.src  = operand[SRC_LSB +: PTR_W];
        end else begin
            pend.mode = OVR_RES;
            pend.res  = operand[SRC_LSB +: PTR_W];
        end
    end
endmodule

// File: rtl/fld_apply.sv
module fld_apply
    import fld_ovr_pkg::*;
(
    input  fields_t plain,
    input  pend_t   pend,
    output fields_t outf
);
    always_comb begin
        outf = plain;
        unique case (pend.mode)
            OVR_RES: outf.res = pend.res;
            OVR_ALL: begin
                outf.res = pend.res;
                outf.dst = pend.dst;
                outf.src = pend.src;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fld_override.sv
module fld_override
    import fld_ovr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              pfx_valid,
    input  logic              pfx_kind,
    input  logic              pfx_cond_ok,
    input  logic [WORD_W-1:0] pfx_operand,
    output logic              dec_valid,
    output logic [CODE_W-1:0] dec_code,
    output logic [PTR_W-1:0]  dec_dst,
    output logic [PTR_W-1:0]  dec_src,
    output logic [PTR_W-1:0]  dec_res
);
    typedef struct packed {
        logic    valid;
        fields_t f;
        pend_t   pend;
    } state_t;

    state_t  st_d, st_q;
    fields_t plain_f, mod_f;
    pend_t   new_pend;

    fld_split u_split (
        .word (in_word),
        .f    (plain_f)
    );

    fld_apply u_apply (
        .plain (plain_f),
        .pend  (st_q.pend),
        .outf  (mod_f)
    );

    fld_pend_build u_build (
        .kind    (pfx_kind),
        .operand (pfx_operand),
        .pend    (new_pend)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (flush) begin
            st_d.pend = '0;
        end else begin
            if (in_valid) begin
                st_d.valid     = 1'b1;
                st_d.f         = mod_f;
                st_d.pend.mode = OVR_NONE;
            end
            if (pfx_valid && pfx_cond_ok) begin
                st_d.pend = new_pend;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dec_valid = st_q.valid;
    assign dec_code  = st_q.f.code;
    assign dec_dst   = st_q.f.dst;
    assign dec_src   = st_q.f.src;
    assign dec_res   = st_q.f.res;

    logic [1:0]       pend_mode_w;
    logic [PTR_W-1:0] pend_res_w;
    assign pend_mode_w = st_q.pend.mode;
    assign pend_res_w  = st_q.pend.res;
endmodule

// File: rtl/fld_override_chk.sv
module fld_override_chk
    import fld_ovr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_word,
    input logic              pfx_valid,
    input logic              pfx_cond_ok,
    input logic              dec_valid,
    input logic [CODE_W-1:0] dec_code,
    input logic [PTR_W-1:0]  dec_dst,
    input logic [PTR_W-1:0]  dec_src,
    input logic [PTR_W-1:0]  dec_res,
    input logic [1:0]        pend_mode,
    input logic [PTR_W-1:0]  pend_res
);
    a_r2_plain_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flush && pend_mode == OVR_NONE) |=>
        (dec_valid && dec_res == $past(in_word[DST_LSB +: PTR_W])
                   && dec_dst == $past(in_word[DST_LSB +: PTR_W])
                   && dec_src == $past(in_word[SRC_LSB +: PTR_W])));

    a_r3_redirect_only_res: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flush && pend_mode == OVR_RES) |=>
        (dec_res == $past(pend_res)
         && dec_dst == $past(in_word[DST_LSB +: PTR_W])
         && dec_src == $past(in_word[SRC_LSB +: PTR_W])));

    a_r4_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flush && pend_mode == OVR_ALL) |=>
        (dec_code == $past(in_word[CODE_LSB +: CODE_W])));

    a_r5_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(pfx_valid && pfx_cond_ok)) |=> (pend_mode == OVR_NONE));

    a_r6_cancel_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (pfx_valid && !pfx_cond_ok && pend_mode == OVR_NONE) |=> (pend_mode == OVR_NONE));

    a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!dec_valid && pend_mode == OVR_NONE));

    a_r9_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !flush) |=> (!dec_valid && $stable(dec_res) && $stable(dec_dst)));
endmodule

bind fld_override fld_override_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .in_valid    (in_valid),
    .in_word     (in_word),
    .pfx_valid   (pfx_valid),
    .pfx_cond_ok (pfx_cond_ok),
    .dec_valid   (dec_valid),
    .dec_code    (dec_code),
    .dec_dst     (dec_dst),
    .dec_src     (dec_src),
    .dec_res     (dec_res),
    .pend_mode   (pend_mode_w),
    .pend_res    (pend_res_w)
);

// File: tb/fld_override_bench.sv
`timescale 1ns/1ps
module fld_override_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        pfx_valid = 1'b0;
    logic        pfx_kind = 1'b0;
    logic        pfx_cond_ok = 1'b0;
    logic [31:0] pfx_operand = '0;
    logic        dec_valid;
    logic [13:0] dec_code;
    logic [8:0]  dec_dst, dec_src, dec_res;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic       m_valid = 0;
    logic [13:0] m_code = '0;
    logic [8:0] m_dst = '0, m_src = '0, m_res = '0;
    int         p_mode = 0;
    logic [8:0] p_res = '0, p_dst = '0, p_src = '0;

    always #2.5 clk = ~clk;

    fld_override u_fld_override (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_word(in_word),
        .pfx_valid(pfx_valid), .pfx_kind(pfx_kind), .pfx_cond_ok(pfx_cond_ok),
        .pfx_operand(pfx_operand), .dec_valid(dec_valid), .dec_code(dec_code),
        .dec_dst(dec_dst), .dec_src(dec_src), .dec_res(dec_res)
    );

    function automatic logic [41:0] pack_exp();
        return {m_valid, m_code, m_dst, m_src, m_res};
    endfunction

    task automatic check(input string tag, input logic [41:0] act, input logic [41:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input bit iv, input logic [31:0] w, input bit pv, input bit kd,
                        input bit ok, input logic [31:0] op, input bit fl, input string tag);
        string t;
        @(negedge clk);
        in_valid = iv; in_word = w; pfx_valid = pv; pfx_kind = kd;
        pfx_cond_ok = ok; pfx_operand = op; flush = fl;
        if (tag != "") t = tag;
        else if (fl) t = "R8";
        else if (!iv) t = "R9";
        else if (p_mode == 1) t = "R3";
        else if (p_mode == 2) t = "R4";
        else t = "R2";
        m_valid = 0;
        if (fl) p_mode = 0;
        else begin
            if (iv) begin
                m_valid = 1; m_code = w[31:18]; m_dst = w[17:9]; m_src = w[8:0]; m_res = w[17:9];
                if (p_mode == 1) m_res = p_res;
                if (p_mode == 2) begin m_res = p_res; m_dst = p_dst; m_src = p_src; end
                p_mode = 0;
            end
            if (pv && ok) begin
                if (!kd) begin p_mode = 1; p_res = op[8:0]; end
                else begin p_mode = 2; p_res = op[27:19]; p_dst = op[17:9]; p_src = op[8:0]; end
            end
        end
        @(posedge clk); #1;
        check(t, {dec_valid, dec_code, dec_dst, dec_src, dec_res}, pack_exp());
    endtask

    localparam logic [31:0] XOR_W = {14'h2B5, 9'd20, 9'd33};

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1", {dec_valid, dec_code, dec_dst, dec_src, dec_res}, 42'd0);
        @(negedge clk); rst_n = 1'b1;
        step(0, '0, 0, 0, 0, '0, 0, "R1");

        // R3: redirect then xor-type word; R5: same word again is plain
        step(0, '0, 1, 0, 1, 32'd300, 0, "R3");
        step(1, XOR_W, 0, 0, 0, '0, 0, "R3");
        tests++;
        if (dec_res !== 9'd300 || dec_dst !== 9'd20 || dec_src !== 9'd33) begin
            fails++;
            $display("FAIL R3: got res=%0d dst=%0d src=%0d expected 300 20 33", dec_res, dec_dst, dec_src);
        end
        step(1, XOR_W, 0, 0, 0, '0, 0, "R5");
        tests++;
        if (dec_res !== 9'd20) begin
            fails++;
            $display("FAIL R5: got res=%0d expected 20", dec_res);
        end

        // R4: alter-all
        step(0, '0, 1, 1, 1, {4'h0, 9'd401, 1'b0, 9'd77, 9'd5}, 0, "R4");
        step(1, XOR_W, 0, 0, 0, '0, 0, "R4");

        // R6: cancelled prefix
        step(0, '0, 1, 0, 0, 32'd99, 0, "R6");
        step(1, XOR_W, 0, 0, 0, '0, 0, "R6");

        // R7: pending waits idle cycles, then decode during new arm
        step(0, '0, 1, 0, 1, 32'd7, 0, "R7");
        step(0, '0, 0, 0, 0, '0, 0, "R7");
        step(1, 32'h1234_5678, 1, 1, 1, {4'h0, 9'd11, 1'b0, 9'd12, 9'd13}, 0, "R7");
        step(1, XOR_W, 0, 0, 0, '0, 0, "R7");
        step(1, XOR_W, 0, 0, 0, '0, 0, "R7");

        // R8: flush kills pending and same-cycle word/prefix
        step(0, '0, 1, 1, 1, 32'hFFFF_FFFF, 0, "R8");
        step(1, XOR_W, 1, 0, 1, 32'd50, 1, "R8");
        step(1, XOR_W, 0, 0, 0, '0, 0, "R8");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rw, ro;
            rw = $urandom; ro = $urandom;
            step($urandom_range(0, 3) != 0, rw, $urandom_range(0, 2) == 0, 1'($urandom),
                 $urandom_range(0, 3) != 0, ro, $urandom_range(0, 19) == 0, "");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule